// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a one-stage arithmetic unit for packed integer data. A 128-bit word is split into equal lanes of 8, 16 or 32 bits. The size code applied with each request picks the lane size. The unit then adds, subtracts, compares for equality or bit-tests the two operands lane by lane. Two further operations ignore lane size and act on the whole word: a bitwise select, which is steered by a third operand, and a bitwise invert.

To issue a request, the caller holds the operands, the size code and the opcode on the inputs and pulses `in_valid` for one cycle. The result is registered and appears one clock later, marked by `res_valid`. If a request has an unsupported size or opcode, the unit raises `err` for one cycle and keeps the previous result.

Top module: `lane_alu`

## Requirements
- R1: Synchronous reset clears `result` to zero and drives `res_valid` and `err` low.
- R2: Size code 0 selects sixteen 8-bit lanes, 1 selects eight 16-bit lanes and 2 selects four 32-bit lanes. Lane 0 holds the least significant bits, and lane numbers rise toward bit 127.
- R3: Opcode 0 adds n and m in each lane, modulo the lane width. No carry passes into the next lane.
- R4: Opcode 1 computes n minus m in each lane, modulo the lane width. No borrow passes into the next lane.
- R5: Opcode 2 sets a result lane to all ones when the n and m lanes are equal, and to all zeros otherwise.
- R6: Opcode 3 sets a result lane to all ones when n AND m is nonzero in that lane, and to all zeros otherwise.
- R7: Opcode 4 returns (d AND n) OR (NOT d AND m) across all 128 bits.
- R8: Opcode 5 returns NOT m across all 128 bits, whatever the legal size code.
- R9: After an accepted strobe, the new result and a one-cycle `res_valid` pulse appear on the next rising clock edge.
- R10: A strobe with size code 3, or with opcode 6 or 7, raises `err` for one cycle. `res_valid` stays low and `result` keeps its earlier value.
- R11: In a cycle with no strobe, `result` holds its value and both `res_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| op_code | input | 3 | 0 add, 1 sub, 2 equal, 3 test, 4 select, 5 invert |
| opnd_n | input | 128 | First operand |
| opnd_m | input | 128 | Second operand |
| opnd_d | input | 128 | Select mask operand |
| result | output | 128 | Registered result |
| res_valid | output | 1 | Pulses high for one cycle when a new result is loaded |
| err | output | 1 | Pulses high for one cycle after an illegal request |

## Verification
The bench drives each request on a falling edge and holds the strobe for exactly one cycle. There is one register stage, so `result`, `res_valid` and `err` all update on the next rising edge. Every check samples them at the falling edge after that, one cycle after the strobe. The hold cases (illegal requests and idle cycles) are sampled at the same point and compared with the value captured before the stimulus. This catches any stray load of the output register.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CEQ = 3'd2;
  localparam logic [2:0] OP_TST = 3'd3;
  localparam logic [2:0] OP_SEL = 3'd4;
  localparam logic [2:0] OP_INV = 3'd5;
  localparam logic [1:0] SZ_BAD = 2'd3;
endpackage

// File: rtl/lane_addsub.sv
// Byte-segmented adder: the carry into each byte is cut at run-time lane starts.
module lane_addsub #(
  parameter int WIDTH = 128,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sz,
  input  logic             sub,
  output logic [WIDTH-1:0] y
);
  localparam int NSEG = WIDTH / SEG_W;

  always_comb begin
    logic             c;
    logic [SEG_W-1:0] bv;
    logic [SEG_W:0]   t;
    int               seg_per_lane;
    c = 1'b0;
    y = '0;
    seg_per_lane = 1 << sz;
    for (int k = 0; k < NSEG; k++) begin
      // lane start: inject sub as carry-in (two's complement), else chain
      if ((k % seg_per_lane) == 0) c = sub;
      bv = sub ? ~b[k*SEG_W +: SEG_W] : b[k*SEG_W +: SEG_W];
      t  = {1'b0, a[k*SEG_W +: SEG_W]} + {1'b0, bv} + {{SEG_W{1'b0}}, c};
      y[k*SEG_W +: SEG_W] = t[SEG_W-1:0];
      c = t[SEG_W];
    end
  end
endmodule

// File: rtl/lane_mask_gen.sv
// Per-segment equal/nonzero flags, reduced over each lane and widened to masks.
module lane_mask_gen #(
  parameter int WIDTH = 128,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sz,
  output logic [WIDTH-1:0] eq_mask,
  output logic [WIDTH-1:0] tst_mask
);
  localparam int NSEG = WIDTH / SEG_W;

  logic [NSEG-1:0] seg_eq, seg_nz;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      assign seg_eq[g] = (a[g*SEG_W +: SEG_W] == b[g*SEG_W +: SEG_W]);
      assign seg_nz[g] = |(a[g*SEG_W +: SEG_W] & b[g*SEG_W +: SEG_W]);
    end
  endgenerate

  always_comb begin
    int   span, base;
    logic all_eq, any_nz;
    eq_mask  = '0;
    tst_mask = '0;
    span = 1 << sz;
    for (int k = 0; k < NSEG; k++) begin
      base   = (k / span) * span;
      all_eq = 1'b1;
      any_nz = 1'b0;
      for (int j = 0; j < 8; j++) begin
        if (j < span && (base + j) < NSEG) begin
          all_eq = all_eq & seg_eq[base + j];
          any_nz = any_nz | seg_nz[base + j];
        end
      end
      eq_mask[k*SEG_W +: SEG_W]  = {SEG_W{all_eq}};
      tst_mask[k*SEG_W +: SEG_W] = {SEG_W{any_nz}};
    end
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu #(
  parameter int WIDTH = 128,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       size_code,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_n,
  input  logic [WIDTH-1:0] opnd_m,
  input  logic [WIDTH-1:0] opnd_d,
  output logic [WIDTH-1:0] result,
  output logic             res_valid,
  output logic             err
);
  import lane_alu_pkg::*;

  logic [WIDTH-1:0] arith_y, eq_y, tst_y, nxt;
  logic             legal;

  lane_addsub #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_addsub (
    .a(opnd_n), .b(opnd_m), .sz(size_code),
    .sub(op_code == OP_SUB), .y(arith_y)
  );

  lane_mask_gen #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_mask (
    .a(opnd_n), .b(opnd_m), .sz(size_code),
    .eq_mask(eq_y), .tst_mask(tst_y)
  );

  assign legal = (size_code != SZ_BAD) && (op_code <= OP_INV);

  always_comb begin
    case (op_code)
      OP_ADD, OP_SUB: nxt = arith_y;
      OP_CEQ:         nxt = eq_y;
      OP_TST:         nxt = tst_y;
      OP_SEL:         nxt = (opnd_d & opnd_n) | (~opnd_d & opnd_m);
      default:        nxt = ~opnd_m;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      res_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      res_valid <= in_valid && legal;
      err       <= in_valid && !legal;
      if (in_valid && legal) result <= nxt;
    end
  end

  // R9
  accept_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal) |=> (res_valid && !err));
  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (err && !res_valid && $stable(result)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !err && $stable(result)));
  // R8
  invert_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && op_code == OP_INV) |=> (result == ~$past(opnd_m)));
  // R7
  select_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && op_code == OP_SEL) |=>
      (result == (($past(opnd_d) & $past(opnd_n)) | (~$past(opnd_d) & $past(opnd_m)))));
endmodule

// File: tb/lane_alu_bench.sv
module lane_alu_bench;
  typedef struct packed {
    logic [1:0]   sz;
    logic [2:0]   op;
    logic [127:0] n;
    logic [127:0] m;
    logic [127:0] d;
    logic [127:0] exp;
  } vec_t;

  // R2..R8 hand-computed vectors
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, {16{8'hFF}}, {16{8'h01}}, 128'h0, 128'h0},                        // R3 8-bit
    '{2'd1, 3'd0, {16{8'hFF}}, {16{8'h01}}, 128'h0, {8{16'h0100}}},                 // R3 16-bit
    '{2'd2, 3'd0, {16{8'hFF}}, {16{8'h01}}, 128'h0, {4{32'h01010100}}},             // R3 32-bit
    '{2'd0, 3'd1, 128'h0, {16{8'h01}}, 128'h0, {16{8'hFF}}},                        // R4 8-bit
    '{2'd1, 3'd1, 128'h0, {8{16'h0001}}, 128'h0, {8{16'hFFFF}}},                    // R4 16-bit
    '{2'd2, 3'd1, {4{32'h00010000}}, {4{32'h1}}, 128'h0, {4{32'h0000FFFF}}},        // R4 32-bit
    '{2'd0, 3'd2, 128'h0, 128'hFF, 128'h0, {{15{8'hFF}}, 8'h00}},                   // R5 8-bit
    '{2'd1, 3'd2, 128'h0, 128'hFF, 128'h0, {{7{16'hFFFF}}, 16'h0000}},              // R5 16-bit
    '{2'd2, 3'd3, {4{32'h80000000}}, {32'h80000000, 96'h0}, 128'h0, {32'hFFFFFFFF, 96'h0}}, // R6 32-bit
    '{2'd0, 3'd3, {16{8'h0F}}, {16{8'hF0}}, 128'h0, 128'h0},                        // R6 8-bit
    '{2'd1, 3'd4, {16{8'hAA}}, {16{8'h55}}, {{8{8'hFF}}, 64'h0}, {{8{8'hAA}}, {8{8'h55}}}}, // R7
    '{2'd1, 3'd5, 128'h0, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0,
      128'hFEDCBA9876543210_0123456789ABCDEF}                                        // R8
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   size_code;
  logic [2:0]   op_code;
  logic [127:0] opnd_n, opnd_m, opnd_d;
  logic [127:0] result;
  logic         res_valid, err;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #2 clk = ~clk;

  lane_alu u_lane_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .op_code(op_code), .opnd_n(opnd_n), .opnd_m(opnd_m), .opnd_d(opnd_d),
    .result(result), .res_valid(res_valid), .err(err)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Lane-by-lane behavioural model written from the requirements
  function automatic logic [127:0] model(input logic [1:0] sz, input logic [2:0] op,
                                         input logic [127:0] n, input logic [127:0] m,
                                         input logic [127:0] d);
    logic [127:0] o;
    logic [31:0]  msk, a, b, r;
    int w;
    if (op == 3'd4) return (d & n) | (~d & m);
    if (op == 3'd5) return ~m;
    w   = 8 << sz;
    msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    o   = '0;
    for (int i = 0; i < 128 / w; i++) begin
      a = 32'(n >> (i * w)) & msk;
      b = 32'(m >> (i * w)) & msk;
      case (op)
        3'd0: r = a + b;
        3'd1: r = a - b;
        3'd2: r = (a == b) ? msk : 32'h0;
        default: r = ((a & b) != 0) ? msk : 32'h0;
      endcase
      o = o | (128'(r & msk) << (i * w));
    end
    return o;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic [2:0] op,
                       input logic [127:0] n, input logic [127:0] m, input logic [127:0] d);
    @(negedge clk);
    in_valid = 1'b1; size_code = sz; op_code = op;
    opnd_n = n; opnd_m = m; opnd_d = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int q = 0; q < 4; q++) begin
      rs = xs(rs);
      v[q*32 +: 32] = rs;
    end
    return v;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [127:0] held, n, m, d;
    rst = 1'b1; in_valid = 1'b0; size_code = 2'd0; op_code = 3'd0;
    opnd_n = '0; opnd_m = '0; opnd_d = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", result, 128'h0);
    check("R1", {127'h0, res_valid}, 128'h0);
    check("R1", {127'h0, err}, 128'h0);
    rst = 1'b0;

    // Table walk (R2..R8), result due one cycle after the strobe (R9)
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].sz, VECS[i].op, VECS[i].n, VECS[i].m, VECS[i].d);
      check(req_of(VECS[i].op), result, VECS[i].exp);
      check("R9", {127'h0, res_valid}, 128'h1);
    end

    // R2 lane order: only lane 0 (lowest bits) affected, 32-bit lanes
    issue(2'd2, 3'd0, 128'h0, 128'h5, 128'h0);
    check("R2", result, 128'h5);

    // Pattern sweep against the model, all legal sizes and ops
    for (int it = 0; it < 60; it++) begin
      logic [1:0] sz;
      logic [2:0] op;
      sz = 2'(it % 3);
      op = 3'((it / 3) % 6);
      n = rnd128(); m = rnd128(); d = rnd128();
      if (it % 4 == 0) m = n ^ (128'hFF << (8 * (it % 16)));
      issue(sz, op, n, m, d);
      check(req_of(op), result, model(sz, op, n, m, d));
    end

    // R8 invert ignores size: same operand, other sizes
    issue(2'd0, 3'd5, 128'h0, {16{8'h3C}}, 128'h0);
    check("R8", result, {16{8'hC3}});
    issue(2'd2, 3'd5, 128'h0, {16{8'h3C}}, 128'h0);
    check("R8", result, {16{8'hC3}});

    // R10 illegal size code 3
    held = result;
    issue(2'd3, 3'd0, {16{8'h11}}, {16{8'h22}}, 128'h0);
    check("R10", {126'h0, err, res_valid}, 128'h2);
    check("R10", result, held);
    // R10 illegal opcodes 6 and 7
    issue(2'd0, 3'd6, {16{8'h11}}, {16{8'h22}}, 128'h0);
    check("R10", {126'h0, err, res_valid}, 128'h2);
    check("R10", result, held);
    issue(2'd1, 3'd7, {16{8'h11}}, {16{8'h22}}, 128'h0);
    check("R10", result, held);

    // R11 idle: inputs change without a strobe
    @(negedge clk);
    opnd_n = {16{8'h77}}; opnd_m = {16{8'h01}}; op_code = 3'd0; size_code = 2'd0;
    @(negedge clk);
    check("R11", result, held);
    check("R11", {126'h0, err, res_valid}, 128'h0);

    // R1 reset mid-run clears result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", result, 128'h0);

    finish_run();
  end
endmodule